// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block collects single-cycle hardware event pulses into a sticky cause register, gates them with an enable mask, and drives one level-sensitive interrupt line toward the host. Software talks to it over a simple 32-bit register bus. A request is a one-cycle `req_i` with `we_i` selecting write or read. Read data appears on `rdata_o` in the cycle after the request.

The implemented cause positions are:

| Bit | Cause |
|-----|-------|
| 0 | transmit descriptor written back |
| 1 | transmit queue empty |
| 2 | link status change |
| 3 | receive framing error |
| 4 | receive descriptors running low |
| 6 | receive overrun |
| 7 | receive timer |
| 9 | management access done |
| 10 | configuration symbols received |
| 12 | PHY event |
| 13 | general-purpose pin |
| 14 | general-purpose pin |
| 15 | transmit descriptors running low |
| 16 | small received frame |

The interrupt service routine reads the cause register once. That read returns every pending cause and clears them all. A zero return tells a shared-line handler that the interrupt was not raised by this block.

Software never writes the mask directly. It sets enable bits through one address and clears them through another, so two agents can change disjoint bits without a read-modify-write. A separate address lets software inject causes for test.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause and mask registers are zero, `irq_o` is low and `rdata_o` is zero.
- R2: An event pulse on `evt_i[b]` for an implemented bit b sets cause bit b. The bit stays set until a cause read.
- R3: A read at offset 0xC0 returns the pending causes on `rdata_o` one cycle later and clears them. An immediate second read returns 0.
- R4: An event that arrives in the same cycle as a cause read is absent from that read's result. It stays pending for the next read.
- R5: A write at offset 0xC8 ORs the implemented bits of `wdata_i` into the cause register, exactly as events would.
- R6: A write at offset 0xD0 sets the mask bits where `wdata_i` is one and leaves the others. A read at 0xD0 returns the current mask.
- R7: A write at offset 0xD8 clears the mask bits where `wdata_i` is one and leaves the others.
- R8: `irq_o` is high exactly while some bit is set in both the cause and the mask. A pending but masked cause keeps it low.
- R9: Bits 5, 8, 11 and 17 through 31 are reserved. They read as zero in both cause and mask, and events or writes on them have no effect.
- R10: Reads at any offset other than 0xC0 and 0xD0 return zero with no side effect. A write at 0xC0 changes nothing. `rdata_o` is zero in the cycle after any non-read cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| evt_i | input | 32 | Event pulses, one bit per cause |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets a cause read that coincides with a new event. A design that clears after merging would lose that event, and one that merges before sampling would report it twice.

It also checks that reserved positions stay zero even when driven from every source. A design with a full-width register would leak those bits into reads and could raise `irq_o` from them.

Mask set and clear writes use partial patterns. A design that loads the mask directly would wipe bits that should be kept. A masked cause written through the set address must stay pending without raising `irq_o`.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned DATA_W = 32;

  // One strobe per register action, decoded from a single bus cycle
  typedef struct packed {
    logic cause_rd;
    logic cause_set;
    logic mask_set;
    logic mask_rd;
    logic mask_clr;
  } acc_t;
endpackage

// File: rtl/irq_cause_decode.sv
module irq_cause_decode
  import irq_cause_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned OFS_CAUSE = 'hC0,
  parameter int unsigned OFS_CSET  = 'hC8,
  parameter int unsigned OFS_MSET  = 'hD0,
  parameter int unsigned OFS_MCLR  = 'hD8
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_CSET  = ADDR_W'(OFS_CSET);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(OFS_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(OFS_MCLR);

  logic rd, wr;
  assign rd = req_i & ~we_i;
  assign wr = req_i & we_i;

  always_comb begin
    acc_o           = '0;
    acc_o.cause_rd  = rd && (addr_i == A_CAUSE);
    acc_o.mask_rd   = rd && (addr_i == A_MSET);
    acc_o.cause_set = wr && (addr_i == A_CSET);
    acc_o.mask_set  = wr && (addr_i == A_MSET);
    acc_o.mask_clr  = wr && (addr_i == A_MCLR);
  end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int unsigned         DATA_W     = 32,
  parameter logic [DATA_W-1:0]   VALID_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              set_i,
  input  logic [DATA_W-1:0] set_bits_i,
  output logic [DATA_W-1:0] cause_o
);
  logic [DATA_W-1:0] cause_q, cause_d;

  // Clear applies to the old value only; same-cycle arrivals survive
  always_comb begin
    cause_d = clr_i ? '0 : cause_q;
    cause_d = cause_d | evt_i;
    if (set_i) cause_d = cause_d | set_bits_i;
    cause_d = cause_d & VALID_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask #(
  parameter int unsigned         DATA_W     = 32,
  parameter logic [DATA_W-1:0]   VALID_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] bits_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (set_i) mask_d = mask_d | bits_i;
    if (clr_i) mask_d = mask_d & ~bits_i;
    mask_d = mask_d & VALID_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 16,
  parameter int unsigned       OFS_CAUSE  = 'hC0,
  parameter int unsigned       OFS_CSET   = 'hC8,
  parameter int unsigned       OFS_MSET   = 'hD0,
  parameter int unsigned       OFS_MCLR   = 'hD8,
  parameter logic [DATA_W-1:0] VALID_MASK = 32'h0001_F6DF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] evt_i,
  output logic              irq_o
);
  acc_t              acc;
  logic [DATA_W-1:0] cause_q, mask_q, wbits, ebits;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  assign wbits = wdata_i & VALID_MASK;
  assign ebits = evt_i & VALID_MASK;

  irq_cause_decode #(
    .ADDR_W(ADDR_W), .OFS_CAUSE(OFS_CAUSE), .OFS_CSET(OFS_CSET),
    .OFS_MSET(OFS_MSET), .OFS_MCLR(OFS_MCLR)
  ) u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .acc_o (acc)
  );

  irq_cause_bank #(.DATA_W(DATA_W), .VALID_MASK(VALID_MASK)) u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (acc.cause_rd),
    .evt_i     (ebits),
    .set_i     (acc.cause_set),
    .set_bits_i(wbits),
    .cause_o   (cause_q)
  );

  irq_cause_mask #(.DATA_W(DATA_W), .VALID_MASK(VALID_MASK)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (acc.mask_set),
    .clr_i (acc.mask_clr),
    .bits_i(wbits),
    .mask_o(mask_q)
  );

  always_comb begin
    rdata_d = '0;
    if (acc.cause_rd)     rdata_d = cause_q;
    else if (acc.mask_rd) rdata_d = mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(cause_q & mask_q);
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned OFS_CAUSE  = 'hC0,
  parameter int unsigned OFS_CSET   = 'hC8,
  parameter int unsigned OFS_MSET   = 'hD0,
  parameter int unsigned OFS_MCLR   = 'hD8,
  parameter logic [31:0] VALID_MASK = 32'h0001_F6DF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       evt_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic [31:0]       cause_i,
  input logic [31:0]       mask_i
);
  logic rd_cause, wr_cset, wr_mset, wr_mclr;
  assign rd_cause = req_i && !we_i && addr_i == ADDR_W'(OFS_CAUSE);
  assign wr_cset  = req_i && we_i && addr_i == ADDR_W'(OFS_CSET);
  assign wr_mset  = req_i && we_i && addr_i == ADDR_W'(OFS_MSET);
  assign wr_mclr  = req_i && we_i && addr_i == ADDR_W'(OFS_MCLR);

  AST_READ_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cause |=> rdata_o == $past(cause_i)); // R3
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cause && (evt_i & VALID_MASK) == 0) |=> cause_i == 0); // R3
  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & VALID_MASK) != 0) |=>
      (cause_i & $past(evt_i & VALID_MASK)) == $past(evt_i & VALID_MASK)); // R4
  AST_CAUSE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cset |=> (cause_i & $past(wdata_i & VALID_MASK)) == $past(wdata_i & VALID_MASK)); // R5
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mset |=> (mask_i & $past(wdata_i & VALID_MASK)) == $past(wdata_i & VALID_MASK)); // R6
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mclr |=> (mask_i & $past(wdata_i)) == 0); // R7
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_i != 0 && cause_i != 0)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_i | mask_i | rdata_o) & ~VALID_MASK) == 0); // R9
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(
  .ADDR_W(ADDR_W), .OFS_CAUSE(OFS_CAUSE), .OFS_CSET(OFS_CSET),
  .OFS_MSET(OFS_MSET), .OFS_MCLR(OFS_MCLR), .VALID_MASK(VALID_MASK)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .evt_i  (evt_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .cause_i(cause_q),
  .mask_i (mask_q)
);

// File: tb/sim_irq_cause_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cause_ctrl;
  localparam int ADDR_W = 16;
  localparam logic [1:0] IDL = 2'd0, RD = 2'd1, WR = 2'd2;
  // {op, addr, wdata, evt, exp_rdata, exp_irq, req_tag}
  localparam int VW = 2 + 16 + 32 + 32 + 32 + 1 + 8;
  localparam int NV = 23;
  localparam logic [VW-1:0] VEC [NV] = '{
    {WR,  16'h00D0, 32'h0001_F6DC, 32'h0,         32'h0,         1'b0, 8'd6},
    {RD,  16'h00D0, 32'h0,         32'h0,         32'h0001_F6DC, 1'b0, 8'd6},
    {IDL, 16'h0000, 32'h0,         32'h1,         32'h0,         1'b0, 8'd8},
    {IDL, 16'h0000, 32'h0,         32'h4,         32'h0,         1'b1, 8'd2},
    {RD,  16'h00C0, 32'h0,         32'h0,         32'h5,         1'b0, 8'd3},
    {RD,  16'h00C0, 32'h0,         32'h0,         32'h0,         1'b0, 8'd3},
    {WR,  16'h00C8, 32'hFFFF_FFFF, 32'h0,         32'h0,         1'b1, 8'd5},
    {RD,  16'h00C0, 32'h0,         32'h0,         32'h0001_F6DF, 1'b0, 8'd9},
    {WR,  16'h00D8, 32'h0001_F6DC, 32'h0,         32'h0,         1'b0, 8'd7},
    {RD,  16'h00D0, 32'h0,         32'h0,         32'h0,         1'b0, 8'd7},
    {WR,  16'h00D0, 32'hFFFF_FFFF, 32'h0,         32'h0,         1'b0, 8'd6},
    {RD,  16'h00D0, 32'h0,         32'h0,         32'h0001_F6DF, 1'b0, 8'd9},
    {IDL, 16'h0000, 32'h0,         32'hFFFE_0920, 32'h0,         1'b0, 8'd9},
    {RD,  16'h00C0, 32'h0,         32'h0,         32'h0,         1'b0, 8'd9},
    {WR,  16'h00C8, 32'h80,        32'h1000,      32'h0,         1'b1, 8'd5},
    {RD,  16'h00C0, 32'h0,         32'h2,         32'h1080,      1'b1, 8'd4},
    {RD,  16'h00C0, 32'h0,         32'h0,         32'h2,         1'b0, 8'd4},
    {WR,  16'h00C0, 32'hFFFF_FFFF, 32'h0,         32'h0,         1'b0, 8'd10},
    {RD,  16'h0004, 32'h0,         32'h0,         32'h0,         1'b0, 8'd10},
    {RD,  16'h00C8, 32'h0,         32'h0,         32'h0,         1'b0, 8'd10},
    {WR,  16'h00D8, 32'h1,         32'h0,         32'h0,         1'b0, 8'd7},
    {WR,  16'h00C8, 32'h1,         32'h0,         32'h0,         1'b0, 8'd8},
    {RD,  16'h00C0, 32'h0,         32'h0,         32'h1,         1'b0, 8'd8}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0, evt = '0;
  logic [31:0]       rdata;
  logic              irq;
  int                n_chk = 0, n_bad = 0;
  bit                done = 1'b0;

  always #2.5 clk = ~clk;

  irq_cause_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [15:0] a,
                       input logic [31:0] d, input logic [31:0] e);
    req = (op != IDL); we = (op == WR); addr = a; wdata = d; evt = e;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(RD, 16'h00C0, 0, 0); @(negedge clk);
    check("R1 cause", rdata, 32'h0);
    drive(RD, 16'h00D0, 0, 0); @(negedge clk);
    check("R1 mask", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(v[VW-1 -: 2], v[VW-3 -: 16], v[VW-19 -: 32], v[VW-51 -: 32]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d rdata", v[7:0], i), rdata, v[40:9]);
      check($sformatf("R%0d vec%0d irq", v[7:0], i), {31'b0, irq}, {31'b0, v[8]});
    end
    drive(IDL, 0, 0, 0);

    // R2: cause holds across idle cycles until read
    drive(IDL, 0, 0, 32'h0000_4000); @(negedge clk);
    drive(IDL, 0, 0, 0); repeat (4) @(negedge clk);
    check("R2 held irq", {31'b0, irq}, 32'h1);
    drive(RD, 16'h00C0, 0, 0); @(negedge clk);
    check("R2 held cause", rdata, 32'h0000_4000);
    drive(IDL, 0, 0, 0); @(negedge clk);
    check("R10 idle rdata", rdata, 32'h0);

    // R1: mid-run reset returns to the reset state
    drive(WR, 16'h00C8, 32'h4, 0); @(negedge clk);
    drive(IDL, 0, 0, 0);
    rst_n = 1'b0; @(negedge clk);
    check("R1 rst irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1; @(negedge clk);
    drive(RD, 16'h00D0, 0, 0); @(negedge clk);
    check("R1 rst mask", rdata, 32'h0);
    drive(IDL, 0, 0, 0); @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule